// File: doc/BRIEF.md
# Scatter-Gather Segment Locator

This block turns a descriptor table that already sits in a small local memory into the list of (address, length) segments a transfer must visit, starting from an arbitrary byte offset. A command engine gives it the command table base address, the command header options word that carries the entry count, the byte offset, and a one-cycle start strobe. The block first scans the table and adds up entry sizes until it finds the entry that holds the offset. It then emits a trimmed first segment, followed by every remaining entry whole, one segment per valid/ready handshake.

Each descriptor occupies 16 bytes. Word 0 holds the low half of a 64-bit buffer address and word 1 the high half. Word 2 is reserved. Word 3 holds a size/flags word whose low 22 bits give the byte count minus one. The block reads the table through a simple request port whose data returns one cycle after the request. When the last segment has been accepted, the block pulses a done flag. When the count is zero or the offset lies beyond the table, it pulses an error flag.

Top module: `sgl_offset_locator`

## Requirements
- R1: Descriptor k is read at byte address tbl_base_i + 0x80 + 16*k, with the address low word at +0, the address high word at +4 and the size/flags word at +12. Read data returns on mem_rdata_i in the cycle after mem_req_o.
- R2: The entry count is hdr_opts_i[31:16], and the low 16 bits of the options word are ignored. A count of zero raises err_o in the cycle after the start strobe, with no memory read and no segment.
- R3: An entry's size in bytes is its size word bits [21:0] plus one. Bits [31:22] of that word have no effect on any segment.
- R4: Entries are summed in index order. The chosen entry is the first one for which offset <= (sum of earlier sizes) + (its own size), and the position within it is the offset minus the sum of earlier sizes.
- R5: If no entry among the counted ones satisfies R4, err_o pulses for exactly one cycle and no segment is emitted.
- R6: The first segment's address is the 64-bit entry address plus the position, carried across bit 32. Its length is the entry size minus the position, and this length is zero when the offset equals the cumulative end of that entry.
- R7: After the first segment, every later entry up to count-1 is emitted in index order with its full address and size, and no entry beyond the count is emitted.
- R8: A segment transfers in a cycle where seg_valid_o and seg_ready_i are both high. While seg_valid_o is high and seg_ready_i is low, seg_addr_o and seg_len_o stay unchanged.
- R9: done_o is high for exactly one cycle, in the cycle after the handshake of the last segment.
- R10: A start strobe that arrives while a walk is in progress is ignored, and the walk's segments and ending are unchanged.
- R11: After reset, seg_valid_o, done_o, err_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| tbl_base_i | input | ADDR_W | Command table base byte address |
| hdr_opts_i | input | 32 | Command header options word (count in [31:16]) |
| offset_i | input | OFFS_W | Starting byte offset into the transfer |
| mem_req_o | output | 1 | Local table memory read request |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_rdata_i | input | 32 | Read data, one cycle after the request |
| seg_valid_o | output | 1 | Segment valid |
| seg_ready_i | input | 1 | Segment accepted by the consumer |
| seg_addr_o | output | 64 | Segment start address |
| seg_len_o | output | SIZE_BITS+1 | Segment length in bytes |
| done_o | output | 1 | One-cycle pulse after the last segment |
| err_o | output | 1 | One-cycle pulse on a zero count or an unmatched offset |

## Verification
The assertions assume a memory that answers every request in the following cycle, and a start strobe that is honoured only while the block is idle. They also rely on the running sum of skipped entries never passing the latched offset. The bench feeds the table from a registered memory model, so data arrives exactly one cycle after each request. It sets each table image before the strobe and does not alter it during a walk. It varies seg_ready_i between always-ready and a two-in-three stall pattern, which exercises the hold rule without breaking the one-cycle latency the search path depends on.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SREQ, ST_SCHK, ST_ELO, ST_EHI, ST_ESZ, ST_ELD, ST_EWAIT, ST_DONE, ST_ERR
  } sgl_state_e;

  localparam int unsigned TBL_OFS     = 32'h80;
  localparam int unsigned ENTRY_SHIFT = 4;
  localparam logic [1:0]  W_ADDR_LO   = 2'd0;
  localparam logic [1:0]  W_ADDR_HI   = 2'd1;
  localparam logic [1:0]  W_SIZE      = 2'd3;
endpackage

// File: rtl/sgl_addr_gen.sv
module sgl_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        word_i,
  output logic [ADDR_W-1:0] addr_o
);
  import sgl_pkg::*;

  always_comb begin
    addr_o = base_i + ADDR_W'(TBL_OFS)
           + (ADDR_W'(idx_i) << ENTRY_SHIFT)
           + (ADDR_W'(word_i) << 2);
  end
endmodule

// File: rtl/sgl_accum.sv
module sgl_accum #(
  parameter int OFFS_W = 32,
  parameter int LEN_W  = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  size_i,
  input  logic [OFFS_W-1:0] offset_i,
  output logic              hit_o,
  output logic [OFFS_W-1:0] pos_o
);
  logic [OFFS_W-1:0] sum_q;
  logic [OFFS_W:0]   end_w;

  // sum only grows on a miss, so it stays below the offset and fits OFFS_W
  always_comb begin
    end_w = {1'b0, sum_q} + (OFFS_W+1)'(size_i);
    hit_o = ({1'b0, offset_i} <= end_w);
    pos_o = offset_i - sum_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_q <= '0;
    else if (clear_i) sum_q <= '0;
    else if (step_i)  sum_q <= end_w[OFFS_W-1:0];
  end

  assert_sum_below_offset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> (sum_q <= offset_i));
endmodule

// File: rtl/sgl_seg_out.sv
module sgl_seg_out #(
  parameter int LEN_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [31:0]      addr_lo_i,
  input  logic [31:0]      addr_hi_i,
  input  logic [LEN_W-1:0] size_i,
  input  logic [LEN_W-1:0] pos_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [63:0]      addr_o,
  output logic [LEN_W-1:0] len_o,
  output logic             fire_o
);
  logic             valid_q;
  logic [63:0]      addr_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      addr_q  <= {addr_hi_i, addr_lo_i} + 64'(pos_i);
      len_q   <= size_i - pos_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign len_o   = len_q;
  assign fire_o  = valid_q & ready_i;

  assert_seg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(addr_q) && $stable(len_q)));

  assert_len_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (len_q <= (LEN_W'(1) << (LEN_W-1))));
endmodule

// File: rtl/sgl_offset_locator.sv
module sgl_offset_locator #(
  parameter int ADDR_W    = 32,
  parameter int OFFS_W    = 32,
  parameter int CNT_W     = 16,
  parameter int SIZE_BITS = 22,
  localparam int LEN_W    = SIZE_BITS + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [31:0]       hdr_opts_i,
  input  logic [OFFS_W-1:0] offset_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic [63:0]       seg_addr_o,
  output logic [LEN_W-1:0]  seg_len_o,
  output logic              done_o,
  output logic              err_o
);
  import sgl_pkg::*;

  sgl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, idx_q;
  logic [OFFS_W-1:0] offset_q;
  logic [LEN_W-1:0]  pos_q;
  logic              first_q;
  logic [31:0]       lo_q, hi_q;

  logic [CNT_W-1:0]  cnt_in;
  logic              opts_unused;
  logic [1:0]        word_sel;
  logic [LEN_W-1:0]  size_w;
  logic              hit_w, step_w, clear_w, load_w, fire_w, last_w, start_ok;
  logic [OFFS_W-1:0] pos_full;
  logic              pos_unused;

  assign cnt_in      = hdr_opts_i[31 -: CNT_W];
  assign opts_unused = ^hdr_opts_i[31-CNT_W:0];
  assign pos_unused  = ^pos_full[OFFS_W-1:LEN_W];
  assign size_w      = LEN_W'(mem_rdata_i[SIZE_BITS-1:0]) + LEN_W'(1);
  assign last_w      = (idx_q == cnt_q - CNT_W'(1));
  assign start_ok    = (state_q == ST_IDLE) && start_i;
  assign clear_w     = start_ok;
  assign step_w      = (state_q == ST_SCHK) && !hit_w;
  assign load_w      = (state_q == ST_ELD);

  always_comb begin
    unique case (state_q)
      ST_ELO:  word_sel = W_ADDR_LO;
      ST_EHI:  word_sel = W_ADDR_HI;
      default: word_sel = W_SIZE;
    endcase
  end

  assign mem_req_o = (state_q == ST_SREQ) || (state_q == ST_ELO) ||
                     (state_q == ST_EHI)  || (state_q == ST_ESZ);

  sgl_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(CNT_W)) i_addr_gen (
    .base_i (base_q),
    .idx_i  (idx_q),
    .word_i (word_sel),
    .addr_o (mem_addr_o)
  );

  sgl_accum #(.OFFS_W(OFFS_W), .LEN_W(LEN_W)) i_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_w),
    .step_i   (step_w),
    .size_i   (size_w),
    .offset_i (offset_q),
    .hit_o    (hit_w),
    .pos_o    (pos_full)
  );

  sgl_seg_out #(.LEN_W(LEN_W)) i_seg_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_w),
    .addr_lo_i (lo_q),
    .addr_hi_i (hi_q),
    .size_i    (size_w),
    .pos_i     (first_q ? pos_q : '0),
    .ready_i   (seg_ready_i),
    .valid_o   (seg_valid_o),
    .addr_o    (seg_addr_o),
    .len_o     (seg_len_o),
    .fire_o    (fire_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = (cnt_in == '0) ? ST_ERR : ST_SREQ;
      ST_SREQ:  state_d = ST_SCHK;
      ST_SCHK:  if (hit_w)       state_d = ST_ELO;
                else if (last_w) state_d = ST_ERR;
                else             state_d = ST_SREQ;
      ST_ELO:   state_d = ST_EHI;
      ST_EHI:   state_d = ST_ESZ;
      ST_ESZ:   state_d = ST_ELD;
      ST_ELD:   state_d = ST_EWAIT;
      ST_EWAIT: if (fire_w) state_d = last_w ? ST_DONE : ST_ELO;
      ST_DONE:  state_d = ST_IDLE;
      ST_ERR:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      offset_q <= '0;
      pos_q    <= '0;
      first_q  <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        base_q   <= tbl_base_i;
        cnt_q    <= cnt_in;
        offset_q <= offset_i;
        idx_q    <= '0;
        first_q  <= 1'b0;
      end
      if (state_q == ST_SCHK) begin
        if (hit_w) begin
          pos_q   <= pos_full[LEN_W-1:0];
          first_q <= 1'b1;
        end else if (!last_w) begin
          idx_q <= idx_q + CNT_W'(1);
        end
      end
      if (state_q == ST_EHI) lo_q <= mem_rdata_i;
      if (state_q == ST_ESZ) hi_q <= mem_rdata_i;
      if (state_q == ST_EWAIT && fire_w) begin
        first_q <= 1'b0;
        if (!last_w) idx_q <= idx_q + CNT_W'(1);
      end
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign err_o  = (state_q == ST_ERR);

  assert_zero_count_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && cnt_in == '0) |=> (err_o && !mem_req_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!seg_valid_o && !mem_req_o && !done_o));

  assert_done_after_fire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(fire_w));
endmodule

// File: tb/test_sgl_offset_locator.sv
module test_sgl_offset_locator;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] tbl_base_i = '0;
  logic [31:0] hdr_opts_i = '0;
  logic [31:0] offset_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        seg_valid_o;
  logic        seg_ready_i = 1'b0;
  logic [63:0] seg_addr_o;
  logic [22:0] seg_len_o;
  logic        done_o, err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] mem [256];

  logic [63:0] got_addr [32];
  logic [63:0] got_len  [32];
  int got_n, req_cnt, done_gap, err_cyc;
  bit got_err, got_done;

  logic [63:0] exp_addr [32];
  logic [63:0] exp_len  [32];
  int exp_n;
  bit exp_err;

  localparam logic [31:0] BASE = 32'h100;

  always #10 clk_i = ~clk_i;

  sgl_offset_locator i_sgl_offset_locator (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tbl_base_i(tbl_base_i),
    .hdr_opts_i(hdr_opts_i), .offset_i(offset_i), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .seg_valid_o(seg_valid_o),
    .seg_ready_i(seg_ready_i), .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o),
    .done_o(done_o), .err_o(err_o)
  );

  always @(posedge clk_i) if (mem_req_o) mem_rdata_i <= mem[mem_addr_o[9:2]];

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int widx(input logic [31:0] base, input int k, input int w);
    return int'(((base + 32'h80 + 32'(k * 16) + 32'(w * 4)) >> 2) & 32'hff);
  endfunction

  task automatic put_entry(input int k, input logic [63:0] a, input logic [31:0] szw);
    mem[widx(BASE, k, 0)] = a[31:0];
    mem[widx(BASE, k, 1)] = a[63:32];
    mem[widx(BASE, k, 2)] = 32'hDEAD_BEEF;
    mem[widx(BASE, k, 3)] = szw;
  endtask

  // independent model of R3/R4/R5/R6/R7
  task automatic model(input logic [31:0] base, input int cnt, input logic [31:0] off);
    longint sum = 0;
    longint sz;
    int found = -1;
    longint pos = 0;
    exp_n = 0;
    exp_err = 0;
    for (int k = 0; k < cnt; k++) begin
      sz = longint'(mem[widx(base, k, 3)] & 32'h003f_ffff) + 1;
      if (longint'(off) <= sum + sz) begin
        found = k;
        pos = longint'(off) - sum;
        break;
      end
      sum += sz;
    end
    if (cnt == 0 || found < 0) begin
      exp_err = 1;
      return;
    end
    for (int k = found; k < cnt; k++) begin
      sz = longint'(mem[widx(base, k, 3)] & 32'h003f_ffff) + 1;
      exp_addr[exp_n] = {mem[widx(base, k, 1)], mem[widx(base, k, 0)]};
      exp_len[exp_n]  = 64'(sz);
      if (k == found) begin
        exp_addr[exp_n] = exp_addr[exp_n] + 64'(pos);
        exp_len[exp_n]  = 64'(sz - pos);
      end
      exp_n++;
    end
  endtask

  task automatic run_walk(input logic [31:0] opts, input logic [31:0] off,
                          input bit stall, input bit inject);
    bit hold = 0;
    bit ended = 0;
    bit rdy;
    logic [63:0] h_addr;
    logic [63:0] h_len;
    int last_fire = -10;
    got_n = 0; got_err = 0; got_done = 0; req_cnt = 0; done_gap = -1; err_cyc = -1;
    @(negedge clk_i);
    tbl_base_i = BASE; hdr_opts_i = opts; offset_i = off; start_i = 1'b1;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (inject && c == 3) begin
        start_i = 1'b1; hdr_opts_i = 32'h0; offset_i = 32'h5; tbl_base_i = 32'h0;
      end
      if (hold) begin
        chk(seg_valid_o && seg_addr_o == h_addr && 64'(seg_len_o) == h_len,
            "R8", "held segment", seg_addr_o, h_addr);
      end
      if (done_o) begin got_done = 1; done_gap = c - last_fire; ended = 1; break; end
      if (err_o)  begin got_err = 1; err_cyc = c; ended = 1; break; end
      if (mem_req_o) req_cnt++;
      rdy = stall ? (c % 3 == 2) : 1'b1;
      seg_ready_i = rdy;
      hold = 0;
      if (seg_valid_o) begin
        if (rdy) begin
          if (got_n < 32) begin
            got_addr[got_n] = seg_addr_o;
            got_len[got_n]  = 64'(seg_len_o);
          end
          got_n++;
          last_fire = c;
        end else begin
          hold = 1; h_addr = seg_addr_o; h_len = 64'(seg_len_o);
        end
      end
    end
    chk(ended, "R9", "walk ended", 64'(ended), 64'd1);
    @(negedge clk_i);
    seg_ready_i = 1'b0;
    chk(!done_o && !err_o, "R9", "end flag one cycle", {done_o, err_o}, 64'd0);
  endtask

  task automatic compare(input string req);
    chk(got_err == exp_err, req, "error flag", 64'(got_err), 64'(exp_err));
    chk(got_n == exp_n, req, "segment count", 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_addr[i] == exp_addr[i], req, $sformatf("seg %0d addr", i), got_addr[i], exp_addr[i]);
      chk(got_len[i] == exp_len[i], req, $sformatf("seg %0d len", i), got_len[i], exp_len[i]);
    end
    if (!exp_err) chk(done_gap == 1, "R9", "done one cycle after last handshake",
                      64'(done_gap), 64'd1);
  endtask

  task automatic t_reset;
    chk(!seg_valid_o && !done_o && !err_o && !mem_req_o, "R11", "reset outputs",
        {seg_valid_o, done_o, err_o, mem_req_o}, 64'd0);
  endtask

  task automatic t_offset_zero;
    model(BASE, 4, 32'd0);
    run_walk(32'h0004_0000, 32'd0, 0, 0);
    compare("R1 R7");
    chk(got_addr[0] == 64'h1_0000_1000, "R1", "entry0 address", got_addr[0], 64'h1_0000_1000);
  endtask

  task automatic t_mid_entry;
    model(BASE, 4, 32'd600);
    run_walk(32'h0004_0000, 32'd600, 1, 0);
    compare("R4 R8");
    chk(got_len[0] == 64'd168, "R4", "trim in entry1", got_len[0], 64'd168);
  endtask

  task automatic t_boundary;
    model(BASE, 4, 32'd512);
    run_walk(32'h0004_0000, 32'd512, 0, 0);
    compare("R6");
    chk(got_len[0] == 64'd0 && got_n == 4, "R6", "zero-length first segment", got_len[0], 64'd0);
  endtask

  task automatic t_carry;
    model(BASE, 4, 32'd800);
    run_walk(32'h0004_0000, 32'd800, 1, 0);
    compare("R6");
    chk(got_addr[0] == 64'h1_0000_0010, "R6", "carry into high word", got_addr[0], 64'h1_0000_0010);
  endtask

  task automatic t_flags;
    model(BASE, 4, 32'd830);
    run_walk(32'h0004_0000, 32'd830, 0, 0);
    compare("R3");
    chk(got_len[1] == 64'd4, "R3", "flag bits ignored", got_len[1], 64'd4);
  endtask

  task automatic t_end;
    model(BASE, 4, 32'd836);
    run_walk(32'h0004_0000, 32'd836, 0, 0);
    compare("R6");
    model(BASE, 4, 32'd837);
    run_walk(32'h0004_0000, 32'd837, 0, 0);
    compare("R5");
    chk(got_err && got_n == 0, "R5", "past end error", 64'(got_n), 64'd0);
  endtask

  task automatic t_count_zero;
    model(BASE, 0, 32'd0);
    run_walk(32'h0000_FFFF, 32'd0, 0, 0);
    chk(got_err && err_cyc == 0, "R2", "zero count error timing", 64'(err_cyc), 64'd0);
    chk(req_cnt == 0 && got_n == 0, "R2", "no reads on zero count", 64'(req_cnt), 64'd0);
  endtask

  task automatic t_count_limit;
    model(BASE, 2, 32'd700);
    run_walk(32'h0002_0045, 32'd700, 0, 0);
    compare("R2 R7");
    chk(got_n == 1 && got_len[0] == 64'd68, "R7", "stops at count", 64'(got_n), 64'd1);
    model(BASE, 2, 32'd800);
    run_walk(32'h0002_0000, 32'd800, 0, 0);
    compare("R5");
  endtask

  task automatic t_restart;
    model(BASE, 4, 32'd100);
    run_walk(32'h0004_0000, 32'd100, 1, 1);
    compare("R10");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    put_entry(0, 64'h0000_0001_0000_1000, 32'h0000_01FF);
    put_entry(1, 64'h0000_0000_0000_2000, 32'h0000_00FF);
    put_entry(2, 64'h0000_0000_FFFF_FFF0, 32'h0000_003F);
    put_entry(3, 64'h0000_0000_0000_8000, 32'hFFC0_0003);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_offset_zero();
    t_mid_entry();
    t_boundary();
    t_carry();
    t_flags();
    t_end();
    t_count_zero();
    t_count_limit();
    t_restart();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule